// File: doc/BRIEF.md
# OSD Serial Command Parser

This block takes bytes from a three-wire serial link (select, clock, data) and turns them into write commands for an on-screen-display register RAM. A frame starts when the select line falls and ends when it rises. Within a frame the data line is sampled on each rising edge of the serial clock, most significant bit first, and every eight bits form one byte. All three serial inputs are brought into the system clock domain through synchronisers, and serial clock edges are found by oversampling. The serial clock must therefore be much slower than the system clock.

Each byte identifies itself by its upper bits:
- A byte that sets the row also picks one of two RAM banks, character address or attribute.
- A byte that sets the column also picks the transfer format.

There are three formats:
- **Format (a), per-write addressing:** each data byte is followed by a fresh row and column.
- **Format (b), same row:** each data byte is followed by a new column only, keeping the row.
- **Format (c), streaming:** every byte is data, and the target address advances after each write. Once a frame enters streaming it cannot leave it.

Every data byte produces a single-cycle write strobe. The strobe carries the row, column, bank and data.

Top module: `osd_cmd_parser`

## Requirements
- R1: After reset the write strobe is low and the row, column, bank and data outputs are zero. Between strobes these outputs do not change.
- R2: A byte consists of eight data-line samples, taken on rising serial clock edges while select is low, most significant bit first. A data byte appears unchanged on the data output with its write strobe.
- R3: A byte with bit 7 = 1, arriving where an address is expected, sets the row from bits 3..0. It sets the bank from bit 5 (0 = address bank, 1 = attribute bank).
- R4: A byte with bit 7 = 0 that follows a row byte, or that follows a data byte in format (a) or (b), sets the column from bits 4..0. If its bit 6 = 0, the next byte is a single data byte.
- R5: In format (a), a row byte, then a column byte, then a data byte produces one write at that row, column and bank. The sequence may repeat any number of times within a frame.
- R6: In format (b), after a data byte, a column byte with bit 6 = 0 followed by a data byte writes at the new column. The row and bank are unchanged.
- R7: A column byte with bit 6 = 1 starts streaming. The first data byte is written at the given row and column, and each later byte at the next address. The column counts up to 30 and then wraps to 0 while the row increments. Row 15 is followed by row 0, and the bank is unchanged.
- R8: Once streaming has started, every byte in that frame is data, including bytes with bit 7 = 1.
- R9: When select goes high, any partial byte is discarded and the parser returns to expecting a row byte. While it expects a row byte, a byte with bit 7 = 0 is ignored. No write occurs while select is high.
- R10: Each data byte produces exactly one write strobe, one system clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ssel_i | input | 1 | Serial select, low during a frame |
| sclk_i | input | 1 | Serial clock, data sampled on its rising edge |
| sdat_i | input | 1 | Serial data, MSB first |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_row_o | output | 4 | Row of the write |
| wr_col_o | output | 5 | Column of the write |
| wr_bank_o | output | 1 | Bank of the write: 0 address, 1 attribute |
| wr_data_o | output | 8 | Data of the write |

## Verification
The bench tests format (a) by sweeping all 16 rows, using a column spread and alternating banks, which separates the row and bank fields from the column field. Format (b) writes every column 0..30 within one row, which shows that the row and bank persist across column bytes. Streaming runs are started near the end of row 14, so the address must wrap at column 30 and again from row 15 to row 0. One long run carries all 256 data values, including those with bit 7 set, to show that streaming cannot be left. A single mixed frame moves from (a) to (b) to (c), and an aborted partial byte followed by a stray column byte shows that raising select fully resets the parser.

// File: rtl/osd_cmd_parser.sv
module osd_cmd_parser #(
  parameter int SYNC     = 2,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 5,
  parameter int LAST_COL = 30,
  parameter int LAST_ROW = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ssel_i,
  input  logic             sclk_i,
  input  logic             sdat_i,
  output logic             wr_stb_o,
  output logic [ROW_W-1:0] wr_row_o,
  output logic [COL_W-1:0] wr_col_o,
  output logic             wr_bank_o,
  output logic [7:0]       wr_data_o
);

  typedef enum logic [2:0] {S_IDLE, S_COL, S_DAT, S_NXT, S_STRM} st_t;

  logic [SYNC-1:0] sel_p, sck_p, sd_p;
  logic            sck_d;
  logic [6:0]      sh;
  logic [2:0]      cnt;
  st_t             state;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic             cur_bank;

  wire       sel_q     = sel_p[SYNC-1];
  wire       sck_q     = sck_p[SYNC-1];
  wire       sd_q      = sd_p[SYNC-1];
  wire       rise      = sck_q & ~sck_d & ~sel_q;
  wire       byte_done = rise & (cnt == 3'd7);
  wire [7:0] byte_v    = {sh, sd_q};
  wire       in_stream = (state == S_STRM);

  wire last_col = (cur_col == COL_W'(LAST_COL));
  wire last_row = (cur_row == ROW_W'(LAST_ROW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_p <= '1;
      sck_p <= '0;
      sd_p  <= '0;
      sck_d <= 1'b0;
    end else begin
      sel_p <= {sel_p[SYNC-2:0], ssel_i};
      sck_p <= {sck_p[SYNC-2:0], sclk_i};
      sd_p  <= {sd_p[SYNC-2:0], sdat_i};
      sck_d <= sck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (sel_q) begin
      cnt <= '0;
    end else if (rise) begin
      sh  <= byte_v[6:0];
      cnt <= cnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_bank  <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_row_o  <= '0;
      wr_col_o  <= '0;
      wr_bank_o <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (sel_q) begin
        state <= S_IDLE;
      end else if (byte_done) begin
        case (state)
          S_IDLE: begin
            if (byte_v[7]) begin
              cur_row  <= byte_v[ROW_W-1:0];
              cur_bank <= byte_v[5];
              state    <= S_COL;
            end
          end
          S_COL, S_NXT: begin
            if (byte_v[7]) begin
              cur_row  <= byte_v[ROW_W-1:0];
              cur_bank <= byte_v[5];
              state    <= S_COL;
            end else begin
              cur_col <= byte_v[COL_W-1:0];
              state   <= byte_v[6] ? S_STRM : S_DAT;
            end
          end
          S_DAT, S_STRM: begin
            wr_stb_o  <= 1'b1;
            wr_row_o  <= cur_row;
            wr_col_o  <= cur_col;
            wr_bank_o <= cur_bank;
            wr_data_o <= byte_v;
            if (state == S_DAT) begin
              state <= S_NXT;
            end else if (last_col) begin
              cur_col <= '0;
              cur_row <= last_row ? '0 : cur_row + ROW_W'(1);
            end else begin
              cur_col <= cur_col + COL_W'(1);
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/osd_cmd_parser_chk.sv
module osd_cmd_parser_chk #(
  parameter int ROW_W    = 4,
  parameter int COL_W    = 5,
  parameter int LAST_COL = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ssel_i,
  input logic             wr_stb_o,
  input logic [ROW_W-1:0] wr_row_o,
  input logic [COL_W-1:0] wr_col_o,
  input logic             wr_bank_o,
  input logic [7:0]       wr_data_o,
  input logic             in_stream
);

  logic [2:0]       hi_cnt;
  logic             prev_ok;
  logic [ROW_W-1:0] prev_row;
  logic [COL_W-1:0] prev_col;
  logic             prev_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      prev_ok   <= 1'b0;
      prev_row  <= '0;
      prev_col  <= '0;
      prev_bank <= 1'b0;
    end else begin
      hi_cnt  <= !ssel_i ? 3'd0 : (hi_cnt == 3'd7 ? hi_cnt : hi_cnt + 3'd1);
      prev_ok <= in_stream ? (prev_ok | wr_stb_o) : 1'b0;
      if (wr_stb_o) begin
        prev_row  <= wr_row_o;
        prev_col  <= wr_col_o;
        prev_bank <= wr_bank_o;
      end
    end
  end

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  p_quiet_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt >= 3'd4) |-> !wr_stb_o);

  p_hold_between_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_o |-> $stable({wr_row_o, wr_col_o, wr_bank_o, wr_data_o}));

  p_stream_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o && in_stream && prev_ok) |->
      (wr_bank_o == prev_bank) &&
      ((prev_col == COL_W'(LAST_COL)) ?
         (wr_col_o == '0 && wr_row_o == ROW_W'(prev_row + ROW_W'(1))) :
         (wr_col_o == COL_W'(prev_col + COL_W'(1)) && wr_row_o == prev_row)));

endmodule

bind osd_cmd_parser osd_cmd_parser_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .LAST_COL(LAST_COL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ssel_i(ssel_i), .wr_stb_o(wr_stb_o),
  .wr_row_o(wr_row_o), .wr_col_o(wr_col_o), .wr_bank_o(wr_bank_o),
  .wr_data_o(wr_data_o), .in_stream(in_stream)
);

// File: tb/osd_cmd_parser_test.sv
module osd_cmd_parser_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ssel = 1'b1, sclk = 1'b0, sdat = 1'b0;
  logic       wr_stb, wr_bank;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [7:0] wr_data;

  int errors = 0, checks = 0;
  logic [17:0] cap [0:511];
  logic [17:0] exp_w [0:511];
  int cap_n = 0, exp_n = 0;
  logic stb_prev = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_cmd_parser uut (
    .clk(clk), .rst_n(rst_n), .ssel_i(ssel), .sclk_i(sclk), .sdat_i(sdat),
    .wr_stb_o(wr_stb), .wr_row_o(wr_row), .wr_col_o(wr_col),
    .wr_bank_o(wr_bank), .wr_data_o(wr_data)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      if (cap_n < 512) cap[cap_n] = {wr_row, wr_col, wr_bank, wr_data};
      cap_n++;
      if (stb_prev) begin
        errors++;
        $display("FAIL R10: strobe high act=2 cycles exp=1 cycle");
      end
    end
    stb_prev = wr_stb;
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdat = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic frame_on;
    ssel = 1'b0;
    wait_clk(6);
  endtask

  task automatic frame_off;
    wait_clk(8);
    ssel = 1'b1;
    wait_clk(8);
  endtask

  task automatic expect_w(input logic [3:0] r, input logic [4:0] c,
                          input logic bk, input logic [7:0] d);
    exp_w[exp_n] = {r, c, bk, d};
    exp_n++;
  endtask

  task automatic verify(input string tag);
    checks++;
    if (cap_n != exp_n) begin
      errors++;
      $display("FAIL %s: write count act=%0d exp=%0d", tag, cap_n, exp_n);
    end
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      checks++;
      if (cap[i] !== exp_w[i]) begin
        errors++;
        $display("FAIL %s: write %0d act=%h exp=%h", tag, i, cap[i], exp_w[i]);
      end
    end
    cap_n = 0;
    exp_n = 0;
  endtask

  task automatic stream_run(input logic [3:0] r0, input logic [4:0] c0,
                            input logic bk, input int n, input int base);
    logic [3:0] r;
    logic [4:0] c;
    r = r0;
    c = c0;
    frame_on();
    send_byte({2'b10, bk, 1'b0, r0});
    send_byte({3'b010, c0});
    for (int i = 0; i < n; i++) begin
      send_byte(8'((base + i) % 256));
      expect_w(r, c, bk, 8'((base + i) % 256));
      if (c == 5'd30) begin
        c = 5'd0;
        r = 4'((r + 1) % 16);
      end else c = c + 5'd1;
    end
    frame_off();
  endtask

  initial begin
    wait_clk(190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    #1;
    checks++;
    if (wr_stb !== 1'b0 || wr_row !== 4'd0 || wr_col !== 5'd0 ||
        wr_bank !== 1'b0 || wr_data !== 8'd0) begin
      errors++;
      $display("FAIL R1: reset outputs act=%b%h%h%b%h exp=0", wr_stb, wr_row,
               wr_col, wr_bank, wr_data);
    end
    rst_n = 1'b1;
    wait_clk(4);

    // R3 R4 R5 R2: format (a) over every row
    frame_on();
    for (int r = 0; r < 16; r++) begin
      send_byte({2'b10, 1'(r % 2), 1'b0, 4'(r)});
      send_byte({3'b000, 5'((r * 7) % 31)});
      send_byte(8'((r * 17 + 3) % 256));
      expect_w(4'(r), 5'((r * 7) % 31), 1'(r % 2), 8'((r * 17 + 3) % 256));
    end
    frame_off();
    verify("R5");
    checks++;
    if (wr_stb !== 1'b0 || wr_row !== 4'd15) begin
      errors++;
      $display("FAIL R1: held outputs act=%b/%0d exp=0/15", wr_stb, wr_row);
    end

    // R6: format (b) across all columns of one row, attribute bank
    frame_on();
    send_byte(8'hA5);
    for (int c = 0; c <= 30; c++) begin
      send_byte({3'b000, 5'(c)});
      send_byte(~8'(c));
      expect_w(4'd5, 5'(c), 1'b1, ~8'(c));
    end
    frame_off();
    verify("R6");

    // R7: streaming with column and row wraps
    stream_run(4'd14, 5'd25, 1'b0, 40, 8'h80);
    verify("R7");

    // R8: all data values in streaming mode
    stream_run(4'd0, 5'd0, 1'b1, 256, 0);
    verify("R8");

    // R4 R5 R6 R7: mixed (a)->(b)->(a)->(c) in one frame
    frame_on();
    send_byte(8'hA2); send_byte(8'h03); send_byte(8'h11);
    expect_w(4'd2, 5'd3, 1'b1, 8'h11);
    send_byte(8'h04); send_byte(8'h22);
    expect_w(4'd2, 5'd4, 1'b1, 8'h22);
    send_byte(8'h83); send_byte(8'h07); send_byte(8'h33);
    expect_w(4'd3, 5'd7, 1'b0, 8'h33);
    send_byte(8'h4A); send_byte(8'h81); send_byte(8'h02); send_byte(8'hC4);
    expect_w(4'd3, 5'd10, 1'b0, 8'h81);
    expect_w(4'd3, 5'd11, 1'b0, 8'h02);
    expect_w(4'd3, 5'd12, 1'b0, 8'hC4);
    frame_off();
    verify("R4");

    // R9: abort partial byte, stray column byte ignored in new frame
    frame_on();
    send_byte(8'h81); send_byte(8'h01);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    frame_off();
    frame_on();
    send_byte(8'h05);
    send_byte(8'h81); send_byte(8'h01); send_byte(8'h55);
    expect_w(4'd1, 5'd1, 1'b0, 8'h55);
    frame_off();
    verify("R9");

    // R9: clock pulses while deselected produce nothing
    send_byte(8'h81); send_byte(8'h01); send_byte(8'h66);
    wait_clk(8);
    verify("R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule